// File: doc/BRIEF.md
# Scan Transaction Clock Sequencer

This block is the host-side master of a serial scan link to a target processor. It drives two clocks, the serial scan clock and the target's CPU clock, and all timing is built from a programmable quarter period counted in system clock cycles. Each level of either clock lasts two quarter periods. A transaction is started by a one-cycle strobe. It runs up to four phases in a fixed order, and each phase has its own enable: a CPU clock pulse, a single scan-clock pulse (which lets the target parallel-load its scan registers), a full scan of the vector, and a closing CPU pulse followed by one scan-clock pulse.

During the scan, the transmit vector leaves on MOSI with the most significant bit first. The receive vector is built from MISO at the same time, and MISO is sampled just before each rising scan-clock edge. The usual transaction enables the first three phases: the target takes one step, its state is snapshotted, and the snapshot is shifted back to the host. Busy covers the whole transaction and done marks its last cycle. Two free-running counters record how many pulses each clock has produced.

Top module: `scan_clock_sequencer`

## Requirements
- R1: After reset, sclk, cpu_clk, mosi, busy and done are 0, and rx_vec, sclk_count and cpu_count are all zero.
- R2: The phases run in the order pre-CPU, pre-scan pulse, scan, post-CPU, and a disabled phase is skipped. With Q = quarter_div and N = 8*num_bytes, busy stays high for 2Q*(2*pre_cpu + pre_sck + scan*(1+2N) + 3*post_cpu) + 1 cycles, starting the cycle after the accepted start. A transaction with no phase enabled is therefore busy for one cycle. sclk and cpu_clk are never high together.
- R3: Every CPU pulse is high for 2Q cycles and then low for 2Q cycles. cpu_count rises by one at each falling edge of cpu_clk.
- R4: Every scan-clock pulse is high for exactly 2Q cycles. This covers the pre-scan pulse, each scanned bit and the pulse after the post-CPU pulse. sclk_count rises by one at each falling edge of sclk.
- R5: The scan first places tx_vec bit N-1 on MOSI and holds it for 2Q cycles before the first rising edge. After each falling edge, MOSI carries the next lower bit. MOSI never changes while sclk is high, so a target that shifts MOSI in on rising edges receives tx_vec[N-1:0] in order, MSB first.
- R6: rx_vec is cleared to zero when a transaction is accepted. rx_vec bit i holds the MISO level sampled on the system clock edge that raises sclk for bit i (bit N-1 first). Bits N and above stay zero.
- R7: After the bit 0 pulse falls, MOSI returns to 0 and stays 0 until the next scan.
- R8: A start is rejected, with no busy, no clock pulse, no counter change and no change to rx_vec, when quarter_div is 0, when num_bytes is 0, or when num_bytes is above MAX_BYTES.
- R9: A start that arrives while busy is high is ignored, including in the cycle where done is high. No second transaction follows.
- R10: done is high for exactly one cycle, which is the last cycle of busy. The next cycle has busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle transaction request |
| en_pre_cpu | input | 1 | Enable the leading CPU pulse |
| en_pre_sck | input | 1 | Enable the single scan pulse before the scan |
| en_scan | input | 1 | Enable the full vector scan |
| en_post_cpu | input | 1 | Enable the closing CPU pulse and scan pulse |
| quarter_div | input | DIV_W | Quarter period in system clock cycles |
| num_bytes | input | NB_W | Bytes in the scanned vector |
| tx_vec | input | 8*MAX_BYTES | Transmit vector; bit 8*num_bytes-1 goes out first |
| miso | input | 1 | Serial data from the target |
| sclk | output | 1 | Serial scan clock |
| cpu_clk | output | 1 | Target CPU clock |
| mosi | output | 1 | Serial data to the target |
| rx_vec | output | 8*MAX_BYTES | Received vector |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Last cycle of a transaction |
| sclk_count | output | CNT_W | Scan-clock pulses since reset |
| cpu_count | output | CNT_W | CPU-clock pulses since reset |

## Verification
A new start can coincide with two things: the done cycle of the running transaction, and an arbitrary cycle in the middle of a scan. The bench provokes both in one run. It raises start a few cycles into a transaction, and again in exactly the cycle where it sees done high. Each transaction's expected item sits in a scoreboard queue. A monitor pops one item per done pulse, so an extra transaction would either find the queue empty or change the counters. After the done cycle, the bench checks that busy stays low and that both counters hold their values. A second coincidence is also checked: the edge that raises sclk for a bit is the same edge on which MISO is sampled. The bench's target shifts on that rising edge, so rx_vec must hold the level seen before the shift.

// File: rtl/sts_pkg.sv
package sts_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE_CPU_HI,
      ST_PRE_CPU_LO,
      ST_PRE_SCK,
      ST_LEAD,
      ST_BIT_HI,
      ST_BIT_LO,
      ST_POST_CPU_HI,
      ST_POST_CPU_LO,
      ST_POST_SCK,
      ST_FINISH
   } seq_state_t;

   typedef struct packed {
      logic pre_cpu;
      logic pre_sck;
      logic scan;
      logic post_cpu;
   } phase_en_t;

   // successor of the scan phase
   function automatic seq_state_t after_scan(phase_en_t en);
      return en.post_cpu ? ST_POST_CPU_HI : ST_FINISH;
   endfunction

   function automatic seq_state_t after_pre_sck(phase_en_t en);
      return en.scan ? ST_LEAD : after_scan(en);
   endfunction

   function automatic seq_state_t after_pre_cpu(phase_en_t en);
      return en.pre_sck ? ST_PRE_SCK : after_pre_sck(en);
   endfunction

   function automatic seq_state_t first_phase(phase_en_t en);
      return en.pre_cpu ? ST_PRE_CPU_HI : after_pre_cpu(en);
   endfunction

endpackage

// File: rtl/sts_half_timer.sv
// Counts one half clock period (two quarter periods) while run is high.
module sts_half_timer #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] qdiv,
   output logic             half_end
);
   localparam int CW = DIV_W + 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   assign limit    = {qdiv, 1'b0} - CW'(1);
   assign half_end = run && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (half_end) cnt <= '0;
      else               cnt <= cnt + CW'(1);
   end

   p_div_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (qdiv != '0));

endmodule

// File: rtl/sts_event_counter.sv
module sts_event_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + CNT_W'(1);
   end

   p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));

endmodule

// File: rtl/sts_scan_shifter.sv
// Holds the captured transmit vector, drives MOSI and assembles the receive vector.
module sts_scan_shifter #(
   parameter  int MAX_BYTES = 8,
   localparam int VEC_W     = 8 * MAX_BYTES,
   localparam int IDX_W     = $clog2(VEC_W),
   localparam int NB_W      = $clog2(MAX_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [VEC_W-1:0] tx_in,
   input  logic [NB_W-1:0]  nbytes_in,
   input  logic             lead,
   input  logic             sample,
   input  logic             advance,
   input  logic             miso,
   output logic             mosi,
   output logic [VEC_W-1:0] rx,
   output logic             last_done
);
   logic [VEC_W-1:0] tx_q;
   logic [IDX_W-1:0] top_q;
   logic [IDX_W-1:0] idx;
   logic [VEC_W-1:0] tx_src;
   logic [IDX_W-1:0] top_new;
   logic [IDX_W-1:0] top_src;

   assign top_new = IDX_W'(int'(nbytes_in) * 8 - 1);
   assign tx_src  = capture ? tx_in   : tx_q;
   assign top_src = capture ? top_new : top_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q      <= '0;
         top_q     <= '0;
         idx       <= '0;
         mosi      <= 1'b0;
         last_done <= 1'b0;
      end else begin
         if (capture) begin
            tx_q  <= tx_in;
            top_q <= top_new;
         end
         if (lead) begin
            mosi      <= tx_src[top_src];
            idx       <= top_src;
            last_done <= 1'b0;
         end else if (advance) begin
            if (idx == '0) begin
               mosi      <= 1'b0;
               last_done <= 1'b1;
            end else begin
               mosi <= tx_q[idx - IDX_W'(1)];
               idx  <= idx - IDX_W'(1);
            end
         end
      end
   end

   for (genvar g = 0; g < VEC_W; g++) begin : g_rx
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              rx[g] <= 1'b0;
         else if (capture)                        rx[g] <= 1'b0;
         else if (sample && idx == IDX_W'(g))     rx[g] <= miso;
      end
   end

   p_mosi_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (last_done && !lead) |-> !mosi);

endmodule

// File: rtl/scan_clock_sequencer.sv
module scan_clock_sequencer
   import sts_pkg::*;
#(
   parameter  int MAX_BYTES = 8,
   parameter  int DIV_W     = 16,
   parameter  int CNT_W     = 32,
   localparam int VEC_W     = 8 * MAX_BYTES,
   localparam int NB_W      = $clog2(MAX_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             en_pre_cpu,
   input  logic             en_pre_sck,
   input  logic             en_scan,
   input  logic             en_post_cpu,
   input  logic [DIV_W-1:0] quarter_div,
   input  logic [NB_W-1:0]  num_bytes,
   input  logic [VEC_W-1:0] tx_vec,
   input  logic             miso,
   output logic             sclk,
   output logic             cpu_clk,
   output logic             mosi,
   output logic [VEC_W-1:0] rx_vec,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] sclk_count,
   output logic [CNT_W-1:0] cpu_count
);
   if (MAX_BYTES < 1) begin : g_bad_bytes
      $error("MAX_BYTES must be at least 1");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   seq_state_t       state, nxt;
   phase_en_t        en_in, en_q;
   logic [DIV_W-1:0] q_q;
   logic             cfg_ok, accept, half_end, run, last_done;
   logic             lead, sample, advance, inc_sclk, inc_cpu;

   assign en_in  = '{pre_cpu: en_pre_cpu, pre_sck: en_pre_sck,
                     scan: en_scan, post_cpu: en_post_cpu};
   assign cfg_ok = (quarter_div != '0) && (num_bytes != '0) &&
                   (int'(num_bytes) <= MAX_BYTES);
   assign accept = start && (state == ST_IDLE) && cfg_ok;

   assign busy    = (state != ST_IDLE);
   assign done    = (state == ST_FINISH);
   assign run     = busy && !done;
   assign sclk    = (state == ST_PRE_SCK) || (state == ST_BIT_HI) ||
                    (state == ST_POST_SCK);
   assign cpu_clk = (state == ST_PRE_CPU_HI) || (state == ST_POST_CPU_HI);

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:        if (accept) nxt = first_phase(en_in);
         ST_PRE_CPU_HI:  if (half_end) nxt = ST_PRE_CPU_LO;
         ST_PRE_CPU_LO:  if (half_end) nxt = after_pre_cpu(en_q);
         ST_PRE_SCK:     if (half_end) nxt = after_pre_sck(en_q);
         ST_LEAD:        if (half_end) nxt = ST_BIT_HI;
         ST_BIT_HI:      if (half_end) nxt = ST_BIT_LO;
         ST_BIT_LO:      if (half_end) nxt = last_done ? after_scan(en_q) : ST_BIT_HI;
         ST_POST_CPU_HI: if (half_end) nxt = ST_POST_CPU_LO;
         ST_POST_CPU_LO: if (half_end) nxt = ST_POST_SCK;
         ST_POST_SCK:    if (half_end) nxt = ST_FINISH;
         ST_FINISH:      nxt = ST_IDLE;
         default:        nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         en_q  <= '0;
         q_q   <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            en_q <= en_in;
            q_q  <= quarter_div;
         end
      end
   end

   assign lead     = (nxt == ST_LEAD) && (state != ST_LEAD);
   assign sample   = half_end && ((state == ST_LEAD) ||
                                  ((state == ST_BIT_LO) && !last_done));
   assign advance  = half_end && (state == ST_BIT_HI);
   assign inc_sclk = half_end && sclk;
   assign inc_cpu  = half_end && cpu_clk;

   sts_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .qdiv     (q_q),
      .half_end (half_end)
   );

   sts_scan_shifter #(.MAX_BYTES(MAX_BYTES)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (accept),
      .tx_in     (tx_vec),
      .nbytes_in (num_bytes),
      .lead      (lead),
      .sample    (sample),
      .advance   (advance),
      .miso      (miso),
      .mosi      (mosi),
      .rx        (rx_vec),
      .last_done (last_done)
   );

   sts_event_counter #(.CNT_W(CNT_W)) u_sclk_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_sclk),
      .count (sclk_count)
   );

   sts_event_counter #(.CNT_W(CNT_W)) u_cpu_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_cpu),
      .count (cpu_count)
   );

   p_clk_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(sclk && cpu_clk));

   p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !cfg_ok) |=> !busy);

   p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> $stable(q_q) && $stable(en_q));

   p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: tb/scan_clock_sequencer_tb.sv
module scan_clock_sequencer_tb;
   localparam int MAXB  = 8;
   localparam int VW    = 8 * MAXB;
   localparam int DIVW  = 16;
   localparam int CW    = 32;
   localparam int NBW   = $clog2(MAXB + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic e_pc = 1'b0, e_ps = 1'b0, e_sc = 1'b0, e_po = 1'b0;
   logic [DIVW-1:0] qdiv = '0;
   logic [NBW-1:0]  nb = '0;
   logic [VW-1:0]   tx = '0;
   logic            miso;
   logic            sclk, cpu_clk, mosi, busy, done;
   logic [VW-1:0]   rx;
   logic [CW-1:0]   sclk_count, cpu_count;

   always #2.5 clk = ~clk;

   scan_clock_sequencer #(.MAX_BYTES(MAXB), .DIV_W(DIVW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .en_pre_cpu(e_pc), .en_pre_sck(e_ps), .en_scan(e_sc), .en_post_cpu(e_po),
      .quarter_div(qdiv), .num_bytes(nb), .tx_vec(tx), .miso(miso),
      .sclk(sclk), .cpu_clk(cpu_clk), .mosi(mosi), .rx_vec(rx),
      .busy(busy), .done(done), .sclk_count(sclk_count), .cpu_count(cpu_count));

   // target model: shifts MOSI in on rising sclk, presents bit N-1 on MISO
   logic [VW-1:0] tgt_init = '0;
   int            gen = 0;
   int            gen_seen = 0;
   logic [VW-1:0] tgt = '0;
   logic [VW-1:0] tgt_view;
   int            cur_nb = 1;
   int            cur_q = 1;

   assign tgt_view = (gen != gen_seen) ? tgt_init : tgt;
   assign miso     = tgt_view[8*cur_nb-1];

   always @(posedge sclk) begin
      tgt      <= {tgt_view[VW-2:0], mosi};
      gen_seen <= gen;
   end

   typedef struct {
      logic [VW-1:0] rx;
      logic [VW-1:0] tgt;
      logic [CW-1:0] cpu;
      logic [CW-1:0] sck;
      int            busy_cyc;
   } exp_t;

   exp_t exp_q[$];
   logic [CW-1:0] exp_cpu = '0;
   logic [CW-1:0] exp_sck = '0;

   int checks = 0, errors = 0;
   int mon_checks = 0, mon_errors = 0;
   int mon_done = 0;

   // ---------------- monitor ----------------
   int   busy_run = 0;
   int   sck_run = 0;
   int   cpu_run = 0;
   logic after_done = 1'b0;
   exp_t e;

   always @(negedge clk) begin
      if (rst_n) begin
         if (after_done) begin
            mon_checks++;
            if (done || busy) begin
               mon_errors++;
               $display("FAIL R10: after done busy=%0b done=%0b expected 0 0", busy, done);
            end
         end
         after_done = 1'b0;
         if (sclk) sck_run++;
         else if (sck_run > 0) begin
            mon_checks++;
            if (sck_run != 2*cur_q) begin
               mon_errors++;
               $display("FAIL R4: sclk high %0d cycles expected %0d", sck_run, 2*cur_q);
            end
            sck_run = 0;
         end
         if (cpu_clk) cpu_run++;
         else if (cpu_run > 0) begin
            mon_checks++;
            if (cpu_run != 2*cur_q) begin
               mon_errors++;
               $display("FAIL R3: cpu_clk high %0d cycles expected %0d", cpu_run, 2*cur_q);
            end
            cpu_run = 0;
         end
         if (busy) busy_run++;
         if (done) begin
            mon_checks++;
            if (exp_q.size() == 0) begin
               mon_errors++;
               $display("FAIL R9: done with no transaction expected (got 1, expected 0)");
            end else begin
               e = exp_q.pop_front();
               if (rx !== e.rx) begin
                  mon_errors++;
                  $display("FAIL R6: rx_vec %h expected %h", rx, e.rx);
               end
               mon_checks++;
               if (tgt_view !== e.tgt) begin
                  mon_errors++;
                  $display("FAIL R5: target got %h expected %h", tgt_view, e.tgt);
               end
               mon_checks++;
               if (cpu_count !== e.cpu) begin
                  mon_errors++;
                  $display("FAIL R3: cpu_count %0d expected %0d", cpu_count, e.cpu);
               end
               mon_checks++;
               if (sclk_count !== e.sck) begin
                  mon_errors++;
                  $display("FAIL R4: sclk_count %0d expected %0d", sclk_count, e.sck);
               end
               mon_checks++;
               if (busy_run != e.busy_cyc) begin
                  mon_errors++;
                  $display("FAIL R2: busy %0d cycles expected %0d", busy_run, e.busy_cyc);
               end
               mon_checks++;
               if (mosi !== 1'b0) begin
                  mon_errors++;
                  $display("FAIL R7: mosi %0b expected 0", mosi);
               end
            end
            busy_run = 0;
            after_done = 1'b1;
            mon_done++;
         end
      end
   end

   // ---------------- driver ----------------
   task automatic check(input bit ok, input string what, input logic [VW-1:0] act,
                        input logic [VW-1:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, expv);
      end
   endtask

   task automatic launch(input bit pc, input bit ps, input bit sc, input bit po,
                         input int q, input int nbytes, input logic [VW-1:0] txv,
                         input logic [VW-1:0] tinit);
      exp_t x;
      logic [VW-1:0] t;
      int nbits;
      nbits = 8 * nbytes;
      t = tinit;
      x.rx = '0;
      if (ps) t = {t[VW-2:0], 1'b0};
      if (sc) begin
         for (int i = nbits - 1; i >= 0; i--) begin
            x.rx[i] = t[nbits-1];
            t = {t[VW-2:0], txv[i]};
         end
      end
      if (po) t = {t[VW-2:0], 1'b0};
      x.tgt = t;
      exp_cpu = exp_cpu + CW'(int'(pc) + int'(po));
      exp_sck = exp_sck + CW'(int'(ps) + (sc ? nbits : 0) + int'(po));
      x.cpu = exp_cpu;
      x.sck = exp_sck;
      x.busy_cyc = 2*q*(2*int'(pc) + int'(ps) + (sc ? 1 + 2*nbits : 0) + 3*int'(po)) + 1;
      exp_q.push_back(x);
      @(negedge clk);
      cur_q = q;
      cur_nb = nbytes;
      tgt_init = tinit;
      gen++;
      e_pc = pc; e_ps = ps; e_sc = sc; e_po = po;
      qdiv = DIVW'(q); nb = NBW'(nbytes); tx = txv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int d0;
      d0 = mon_done;
      while (mon_done == d0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_txn(input bit pc, input bit ps, input bit sc, input bit po,
                          input int q, input int nbytes, input logic [VW-1:0] txv,
                          input logic [VW-1:0] tinit);
      launch(pc, ps, sc, po, q, nbytes, txv, tinit);
      wait_done();
   endtask

   task automatic try_reject(input int q, input int nbytes, input string why);
      logic [VW-1:0] rx0;
      logic [CW-1:0] s0, c0;
      bit seen_busy;
      rx0 = rx; s0 = sclk_count; c0 = cpu_count;
      seen_busy = 0;
      @(negedge clk);
      e_pc = 1; e_ps = 1; e_sc = 1; e_po = 1;
      qdiv = DIVW'(q); nb = NBW'(nbytes); tx = '1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 8; k++) begin
         if (busy || sclk || cpu_clk) seen_busy = 1;
         @(negedge clk);
      end
      check(!seen_busy, {"R8 busy/pulse on ", why}, VW'(seen_busy), '0);
      check(rx === rx0 && sclk_count === s0 && cpu_count === c0,
            {"R8 state changed on ", why}, rx, rx0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(sclk === 0 && cpu_clk === 0 && mosi === 0, "R1 clocks/mosi", {sclk, cpu_clk, mosi}, '0);
      check(busy === 0 && done === 0, "R1 busy/done", {busy, done}, '0);
      check(rx === '0 && sclk_count === '0 && cpu_count === '0, "R1 vectors/counters", rx, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // usual snapshot transaction: R2 R3 R4 R5 R6
      run_txn(1, 1, 1, 0, 1, 2, 64'h0000_0000_0000_A5C3, 64'h0000_0000_0000_3C96);
      // scan only, slower: R5 R6 R7
      run_txn(0, 0, 1, 0, 2, 1, 64'h0000_0000_0000_0081, 64'h0000_0000_0000_00F0);
      // all four phases: R2 R3 R4
      run_txn(1, 1, 1, 1, 3, 3, 64'h0000_0000_00DE_AD5A, 64'h0000_0000_0012_3456);
      // post phase only: R3 R4
      run_txn(0, 0, 0, 1, 1, 1, '0, 64'h0000_0000_0000_00FF);
      // no phase: one busy cycle, R2
      run_txn(0, 0, 0, 0, 2, 1, '0, '0);
      // full width: R5 R6
      run_txn(0, 0, 1, 0, 1, MAXB, 64'hF0E1_D2C3_B4A5_9687, 64'h1357_9BDF_0246_8ACE);
      // pre-CPU only: R3
      run_txn(1, 0, 0, 0, 2, 1, '0, '0);

      // rejected configurations: R8
      try_reject(0, 2, "zero divider");
      try_reject(1, 0, "zero bytes");
      try_reject(1, MAXB + 1, "too many bytes");

      // R9: start mid-transaction and in the done cycle
      begin
         logic [CW-1:0] s0, c0;
         bit extra;
         launch(1, 1, 1, 0, 1, 1, 64'h0000_0000_0000_005A, 64'h0000_0000_0000_00C3);
         repeat (5) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         while (!done) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         s0 = sclk_count; c0 = cpu_count;
         extra = 0;
         for (int k = 0; k < 10; k++) begin
            if (busy) extra = 1;
            @(negedge clk);
         end
         check(!extra, "R9 start while busy/done restarted", VW'(extra), '0);
         check(sclk_count === s0 && cpu_count === c0, "R9 counters moved", VW'(sclk_count), VW'(s0));
         check(exp_q.size() == 0, "R9 scoreboard drained", VW'(exp_q.size()), '0);
      end

      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors",
               checks + mon_checks, errors + mon_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("Simulation finished: %0d checks, %0d errors",
               checks + mon_checks + 1, errors + mon_errors + 1);
      $finish;
   end

endmodule